// File: doc/BRIEF.md
# Single-Byte I2C Master Engine

This block is an I2C master with 7-bit addressing. Each request runs exactly one transaction, which either writes one data byte to a target or reads one byte back from it. The block controls each bus line through an open-drain output enable. A line goes low only when its enable is asserted, and it goes high only when the enable is released and the external pull-up raises it. The block samples both bus lines through two-flop synchronizers.

All bus timing comes from a 1 us tick. A parameterized divider derives the tick from the system clock. A clock low phase lasts `T_LOW_US` and a clock high phase lasts `T_HIGH_US`, which are 3 us and 5 us by default. After reset both lines stay released and the block waits `RESET_US` before it accepts a request. After each stop it holds an idle gap of `GAP_US`. A one-cycle `done_o` pulse marks the end of that gap.

A missing acknowledge sets a flag and the transfer still finishes. A bus that is already low when a request is accepted also sets a flag and the transfer still runs. On a read the master always acknowledges the byte.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both line enables are released and `busy_o` stays high for `RESET_US` microseconds. A `start_i` seen during that wait is ignored. `done_o`, `nack_o`, `bus_busy_o` and `rdata_o` all read 0.
- R2: A start condition begins in the cycle after `start_i` is accepted in idle. SDA is pulled low while SCL is released. SCL is pulled low `T_HIGH_US` later. Each transaction shows exactly one start condition on the bus.
- R3: Every SCL high pulse lasts `T_HIGH_US`. SDA changes only while SCL is low, except at the start and stop conditions. A transaction has 18 bit clocks: 9 for the address byte and 9 for the data byte, each byte followed by its acknowledge slot.
- R4: The first byte is sent MSB first. It is `{addr_i, rd_i}`, where a read is 1 and a write is 0.
- R5: On a write, `wdata_i` is sent MSB first. SDA is released in both acknowledge slots. `nack_o` is set if SDA reads high at the end of the high phase of either slot. The transfer runs to its stop either way.
- R6: On a read, SDA is released for 8 bit clocks. The bits are shifted MSB first into `rdata_o`, each sampled at the end of its SCL high phase. `wdata_i` has no effect on a read. On the ninth clock the master drives SDA low.
- R7: For the stop, SDA is held low while SCL is released. SDA is released `T_HIGH_US` later. `done_o` pulses for exactly one cycle `GAP_US` after SDA is released. `busy_o` falls in the same cycle as that pulse.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. No further transaction starts after the current one ends.
- R9: `bus_busy_o` is set if either line reads low when a request is accepted, and the transfer still runs. `nack_o` and `bus_busy_o` are cleared only when a new request is accepted. While the block is idle, both flags and `rdata_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| rd_i | input | 1 | 1 = read one byte, 0 = write one byte |
| addr_i | input | 7 | Target address |
| wdata_i | input | 8 | Byte to write |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| rdata_o | output | 8 | Byte received by the last read |
| busy_o | output | 1 | High during the reset wait and during a transaction, including its idle gap |
| done_o | output | 1 | One-cycle pulse when the idle gap ends |
| nack_o | output | 1 | An acknowledge slot read high |
| bus_busy_o | output | 1 | A line was low when the request was accepted |

## Verification
The bench sweeps all 128 addresses with a varied mix of reads and writes. A bus-level target model decodes the bit clocks and drives acknowledges and read data. This exposes a wrong read/write bit, an LSB-first shift, or a read byte shifted one slot off.

Other checks measure the start hold time, every SCL high width, and the stop-to-done gap in nanoseconds. A sequencer with a phase off by one tick, or a divider that is not restarted on each request, would change these times.

Dedicated cases cover several faults:
- A target that never acknowledges, where a design that aborts would lose the stop.
- An SCL line held low at the moment of the request, where a design that waits would never finish.
- A second request issued mid-transfer, where a design that takes it would start an extra frame.
- A request issued during the reset wait.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [3:0] {
    ST_RST, ST_IDLE, ST_STA_A, ST_STA_B, ST_BIT_SU, ST_BIT_HI, ST_BIT_LO,
    ST_STO_A, ST_STO_B, ST_GAP
  } state_e;

  localparam int unsigned FRAME_SLOTS     = 18;
  localparam int unsigned ADDR_ACK_SLOT   = 8;
  localparam int unsigned DATA_FIRST_SLOT = 9;
  localparam int unsigned DATA_LAST_SLOT  = 16;
  localparam int unsigned SLOT_W          = $clog2(FRAME_SLOTS);
endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // lines idle high, so the synchronizer resets to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_us_tick.sv
module i2c_us_tick #(
  parameter int unsigned DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned TW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [TW-1:0] len_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == len_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
  import i2c_bm_pkg::*;
#(
  parameter int unsigned TW        = 13,
  parameter int unsigned T_LOW_US  = 3,
  parameter int unsigned T_HIGH_US = 5,
  parameter int unsigned GAP_US    = 1000,
  parameter int unsigned RESET_US  = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [6:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          expire_i,
  output logic [TW-1:0] ph_len_o,
  output logic          tmr_clr_o,
  output logic          tick_clr_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic [7:0]    rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          nack_o,
  output logic          bus_busy_o
);
  state_e                 st_q;
  logic [FRAME_SLOTS-1:0] frame_q;  // 1 = release SDA in that slot
  logic [SLOT_W-1:0]      slot_q;
  logic                   rd_q;
  logic                   accept, last_slot, ack_slot, rx_slot, tx_bit;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign last_slot = (slot_q == SLOT_W'(FRAME_SLOTS - 1));
  assign ack_slot  = (slot_q == SLOT_W'(ADDR_ACK_SLOT)) || (last_slot && !rd_q);
  assign rx_slot   = rd_q && (slot_q >= SLOT_W'(DATA_FIRST_SLOT)) &&
                     (slot_q <= SLOT_W'(DATA_LAST_SLOT));
  assign tx_bit    = frame_q[FRAME_SLOTS-1];

  assign tmr_clr_o  = expire_i | accept;
  assign tick_clr_o = accept;
  assign busy_o     = (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_RST:                         ph_len_o = TW'(RESET_US);
      ST_STA_A, ST_BIT_HI, ST_STO_B:  ph_len_o = TW'(T_HIGH_US);
      ST_STA_B, ST_BIT_SU, ST_BIT_LO,
      ST_STO_A:                       ph_len_o = TW'(T_LOW_US);
      ST_GAP:                         ph_len_o = TW'(GAP_US);
      default:                        ph_len_o = TW'(1);
    endcase
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (st_q)
      ST_STA_A:             sda_oe_o = 1'b1;
      ST_STA_B, ST_STO_A: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      ST_BIT_SU, ST_BIT_LO: begin scl_oe_o = 1'b1; sda_oe_o = !tx_bit; end
      ST_BIT_HI:            sda_oe_o = !tx_bit;
      ST_STO_B:             sda_oe_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RST;
      frame_q    <= '1;
      slot_q     <= '0;
      rd_q       <= 1'b0;
      rdata_o    <= '0;
      nack_o     <= 1'b0;
      bus_busy_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= (st_q == ST_GAP) && expire_i;
      if (accept) begin
        st_q       <= ST_STA_A;
        rd_q       <= rd_i;
        slot_q     <= '0;
        nack_o     <= 1'b0;
        bus_busy_o <= !(scl_s_i && sda_s_i);
        frame_q    <= {addr_i, rd_i, 1'b1, (rd_i ? 8'hff : wdata_i), !rd_i};
      end else if (expire_i) begin
        unique case (st_q)
          ST_RST:    st_q <= ST_IDLE;
          ST_STA_A:  st_q <= ST_STA_B;
          ST_STA_B:  st_q <= ST_BIT_SU;
          ST_BIT_SU: st_q <= ST_BIT_HI;
          ST_BIT_HI: begin
            st_q <= ST_BIT_LO;
            if (ack_slot && sda_s_i) nack_o <= 1'b1;
            if (rx_slot) rdata_o <= {rdata_o[6:0], sda_s_i};
          end
          ST_BIT_LO: begin
            if (last_slot) st_q <= ST_STO_A;
            else begin
              st_q    <= ST_BIT_SU;
              slot_q  <= slot_q + SLOT_W'(1);
              frame_q <= {frame_q[FRAME_SLOTS-2:0], 1'b1};
            end
          end
          ST_STO_A:  st_q <= ST_STO_B;
          ST_STO_B:  st_q <= ST_GAP;
          default:   st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int unsigned CLK_PER_US  = 125,
  parameter int unsigned T_LOW_US    = 3,
  parameter int unsigned T_HIGH_US   = 5,
  parameter int unsigned GAP_US      = 1000,
  parameter int unsigned RESET_US    = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [6:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       bus_busy_o
);
  localparam int unsigned MAX_US = (RESET_US > GAP_US) ? RESET_US : GAP_US;
  localparam int unsigned TW     = $clog2(MAX_US + 1);

  logic [1:0]    lines_in, lines_s;
  logic          tick, tick_clr, tmr_clr, expire;
  logic [TW-1:0] ph_len;

  assign lines_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (lines_in[g]),
      .q_o   (lines_s[g])
    );
  end

  i2c_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .tick_o(tick)
  );

  i2c_phase_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .clr_i   (tmr_clr),
    .len_i   (ph_len),
    .expire_o(expire)
  );

  i2c_bm_seq #(
    .TW(TW), .T_LOW_US(T_LOW_US), .T_HIGH_US(T_HIGH_US),
    .GAP_US(GAP_US), .RESET_US(RESET_US)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .scl_s_i   (lines_s[1]),
    .sda_s_i   (lines_s[0]),
    .expire_i  (expire),
    .ph_len_o  (ph_len),
    .tmr_clr_o (tmr_clr),
    .tick_clr_o(tick_clr),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .rdata_o   (rdata_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .nack_o    (nack_o),
    .bus_busy_o(bus_busy_o)
  );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       nack_o,
  input logic       bus_busy_o,
  input logic [7:0] rdata_o
);
  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_at_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  a_r2_start_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (sda_oe_o && !scl_oe_o));

  a_r3_sda_low_only_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && $past(!scl_oe_o) && $rose(sda_oe_o)) |-> $rose(busy_o));

  a_r9_flags_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(nack_o) && $stable(bus_busy_o) && $stable(rdata_o)));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (.*);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  localparam int P      = 2;
  localparam int GAP    = 10;
  localparam int RST_US = 20;
  localparam int CYC    = 8;
  localparam int HI_NS  = 5 * P * CYC;
  localparam int GAP_NS = GAP * P * CYC;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, rd_i = 0;
  logic [6:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic scl_oe, sda_oe, busy, done, nack, bus_busy;
  logic [7:0] rdata;
  logic scl_w, sda_w;
  logic tgt_low = 0, frc_scl = 0;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  assign scl_w = !(scl_oe || frc_scl);
  assign sda_w = !(sda_oe || tgt_low);

  i2c_byte_master #(.CLK_PER_US(P), .GAP_US(GAP), .RESET_US(RST_US)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .rdata_o(rdata), .busy_o(busy),
    .done_o(done), .nack_o(nack), .bus_busy_o(bus_busy)
  );

  // bus monitor and target model
  logic t_rd = 0, t_nack = 0;
  logic [7:0] t_rbyte = 0;
  logic prev_scl = 1, prev_sda = 1, in_frame = 0;
  int nr = 0, fcnt = 0, starts = 0, stops = 0, bad_w = 0;
  time t_start = 0, t_rise = 0, t_stop = 0, t_done = 0;
  logic cap [0:31];

  always @(scl_w or sda_w) begin
    if (scl_w && prev_scl && prev_sda && !sda_w) begin
      starts++; in_frame = 1; nr = 0; fcnt = 0; t_start = $time;
    end else if (scl_w && prev_scl && !prev_sda && sda_w) begin
      stops++; in_frame = 0; t_stop = $time;
    end
    if (scl_w && !prev_scl && in_frame) begin
      if (nr < 32) cap[nr] = sda_w;
      nr++; t_rise = $time;
    end
    if (!scl_w && prev_scl && in_frame) begin
      if (fcnt == 0) begin
        if ($time - t_start != HI_NS) bad_w++;
      end else if ($time - t_rise != HI_NS) bad_w++;
      if (fcnt == 8) tgt_low = !t_nack;
      else if (fcnt >= 9 && fcnt <= 16) tgt_low = t_rd && !t_rbyte[16-fcnt];
      else if (fcnt == 17) tgt_low = !t_rd && !t_nack;
      else tgt_low = 0;
      fcnt++;
    end
    prev_scl = scl_w;
    prev_sda = sda_w;
  end

  always @(posedge done) t_done = $time;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    seen = done;
  endtask

  task automatic run_txn(input logic [6:0] a, input logic r, input logic [7:0] d,
                         input logic nk, input logic ign);
    int st0, sp0, bw0;
    bit seen;
    logic [7:0] got_a, got_d;
    t_rd = r; t_nack = nk; t_rbyte = d;
    st0 = starts; sp0 = stops; bw0 = bad_w;
    @(negedge clk);
    start_i = 1; rd_i = r; addr_i = a; wdata_i = r ? 8'h5a : d;
    @(negedge clk);
    start_i = 0;
    chk(busy == 1, "R2 busy after accept", busy, 1);
    if (ign) begin
      repeat (100) @(negedge clk);
      start_i = 1; addr_i = ~a; rd_i = ~r; wdata_i = ~d;
      @(negedge clk);
      start_i = 0;
    end
    wait_done(seen);
    chk(seen, "R7 done pulse", seen, 1);
    chk(busy == 0, "R7 busy low with done", busy, 0);
    for (int i = 0; i < 8; i++) begin
      got_a[7-i] = cap[i];
      got_d[7-i] = cap[9+i];
    end
    chk(starts - st0 == 1, "R2 one start", starts - st0, 1);
    chk(stops - sp0 == 1, "R7 one stop", stops - sp0, 1);
    chk(nr == 19, "R3 bit clocks plus stop rise", nr, 19);
    chk(bad_w == bw0, "R3 high width / R2 start hold", bad_w - bw0, 0);
    chk(got_a == {a, r}, "R4 address byte", got_a, {a, r});
    chk(got_d == d, r ? "R6 read byte on bus" : "R5 write byte", got_d, d);
    chk(cap[8] == nk, "R5 address ack slot", cap[8], nk);
    chk(cap[17] == (r ? 1'b0 : nk), r ? "R6 master ack" : "R5 data ack slot",
        cap[17], r ? 0 : nk);
    chk(nack == nk, "R5 nack flag", nack, nk);
    chk(bus_busy == 0, "R9 bus flag clear", bus_busy, 0);
    chk(t_done - t_stop == GAP_NS, "R7 idle gap", t_done - t_stop, GAP_NS);
    if (r) chk(rdata == d, "R6 rdata", rdata, d);
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
    if (ign) begin
      repeat (40) @(negedge clk);
      chk(busy == 0 && starts == st0 + 1, "R8 request ignored while busy", starts - st0, 1);
    end
  endtask

  task automatic run_bus_held();
    bit seen;
    t_rd = 0; t_nack = 1; t_rbyte = 0;
    frc_scl = 1;
    repeat (5) @(negedge clk);
    start_i = 1; rd_i = 0; addr_i = 7'h03; wdata_i = 8'h3c;
    @(negedge clk);
    start_i = 0;
    repeat (2) @(negedge clk);
    frc_scl = 0;
    wait_done(seen);
    chk(seen, "R9 transfer still completes", seen, 1);
    chk(bus_busy == 1, "R9 bus-not-idle flag", bus_busy, 1);
    repeat (20) @(negedge clk);
    chk(bus_busy == 1, "R9 flag held while idle", bus_busy, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(busy == 1, "R1 busy in reset wait", busy, 1);
    chk(done == 0 && nack == 0 && bus_busy == 0 && rdata == 0, "R1 outputs zero",
        {done, nack, bus_busy, rdata}, 0);
    repeat (8) @(negedge clk);
    start_i = 1; addr_i = 7'h11;
    @(negedge clk);
    start_i = 0;
    repeat (24) @(negedge clk);
    chk(busy == 1, "R1 still waiting", busy, 1);
    repeat (10) @(negedge clk);
    chk(busy == 0, "R1 wait ends", busy, 0);
    chk(starts == 0, "R1 request during wait ignored", starts, 0);

    for (int a = 0; a < 128; a++)
      run_txn(7'(a), (a % 3) == 0, 8'(a * 37 + 11), (a == 5) || (a == 77), a == 40);
    run_txn(7'h7f, 0, 8'h00, 0, 0);
    run_txn(7'h00, 1, 8'hff, 0, 0);
    run_txn(7'h55, 1, 8'h00, 1, 0);
    run_txn(7'h2a, 0, 8'hff, 1, 0);
    run_bus_held();
    run_txn(7'h31, 1, 8'ha5, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule